// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block lets a host processor run single-register management transactions with an external Ethernet PHY over the two-wire MDC/MDIO bus. The host sees two 32-bit registers. One is the data register. The other is the command register, which holds the PHY address, the register number, a clock-select field, a write flag and a busy flag. Setting the busy flag in a command write launches one complete management frame. The hardware clears the flag once the last bit of that frame has been clocked out.

For a write transaction, the host first loads the data register and then issues the command. The frame carries the data value that was present when the command was accepted. For a read transaction, the controller releases MDIO from the turnaround through the data field and samples the line on each rising MDC edge. The 16 bits it collects are in the data register by the time busy reads back as 0. The MDC rate is the system clock divided by a power-of-two ratio chosen by the 3-bit select field. MDC idles low and MDIO is undriven between frames.

The sequencer has five states:
- `ST_IDLE`: bus quiet.
- `ST_PREAMBLE`: 32 driven ones.
- `ST_HEADER`: start code, opcode, PHY address and register number, 14 bits.
- `ST_TURN`: two turnaround bits.
- `ST_DATA`: 16 data bits.

Transitions:
- IDLE to PREAMBLE on an accepted command.
- PREAMBLE to HEADER after the 32nd bit slot.
- HEADER to TURN after the 14th slot.
- TURN to DATA after the 2nd slot.
- DATA back to IDLE after the 16th slot. This transition is also the cycle in which busy clears.

Top module: `mdio_ctrl`

## Requirements
- R1: After reset both registers read 0, MDC is low and MDIO output enable is low.
- R2: A command write with bit 31 (busy) set while busy is 0 sets busy on the next cycle. Busy stays 1 for exactly 64 MDC rising edges and then returns to 0.
- R3: Every frame, sampled at MDC rising edges, begins with 32 ones, then start code 01, then opcode 01 for a write or 10 for a read, then the 5-bit PHY address from command bits [4:0], then the 5-bit register number from command bits [12:8]. All fields are sent MSB first and MDIO is driven throughout.
- R4: In a write frame (command bit 30 set), the turnaround is driven as 10, followed by data register bits [15:0] MSB first.
- R5: In a read frame (command bit 30 clear), MDIO output enable is low for the 2 turnaround and 16 data bit slots. The 16 values on the MDIO input at the data-slot rising edges appear, MSB first, in data register bits [15:0] with bits [31:16] zero, by the time busy reads 0.
- R6: MDC high and low phases each last 2 << sel system clock cycles, where sel is command bits [18:16].
- R7: While busy is 0, MDC is low and MDIO output enable is low.
- R8: A command register write while busy is 1 is ignored. The command value is unchanged and no extra frame follows.
- R9: A data register write during a write frame does not alter the bits sent. The new value is readable afterwards.
- R10: A command write with bit 31 clear stores the whole word as written and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Register write strobe |
| host_sel | input | 1 | Register select: 0 command, 1 data |
| host_wdata | input | 32 | Register write data |
| cmd_rdata | output | 32 | Command register contents |
| data_rdata | output | 32 | Data register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench runs frames at the fastest, a middle and the slowest divider settings. It measures every MDC high phase, so a divider table that is off by one would stretch or shorten the clock. It counts rising edges per frame, which catches a busy flag that drops a slot early or late and also catches a sequencer that loses a header bit. During a frame, it tries to overwrite both the command and the data register. A controller that accepted the command would change its fields or chain a second frame. One that sent data live from the register would corrupt the bits on the wire. Read frames use patterns with set MSB and LSB, which expose a capture that is shifted by one edge or that leaves the line driven during turnaround.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } mdio_state_t;

    // command register field positions
    localparam int PHY_LSB  = 0;
    localparam int REG_LSB  = 8;
    localparam int SEL_LSB  = 16;
    localparam int WR_BIT   = 30;
    localparam int BUSY_BIT = 31;

    localparam int FIELD_W  = 5;
    localparam int SEL_W    = 3;
    localparam int DATA_W   = 16;
    localparam int HOST_W   = 32;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_BASE = 2,
    parameter int SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             mdc,
    output logic             rise_pulse,
    output logic             slot_end
);
    localparam int N_SEL    = 1 << SEL_W;
    localparam int MAX_HALF = DIV_BASE << (N_SEL - 1);
    localparam int CNT_W    = $clog2(MAX_HALF) + 1;

    logic [CNT_W-1:0] half_tab [N_SEL];
    logic [CNT_W-1:0] cnt_q;
    logic             phase_q;
    logic             wrap;

    // terminal count per select value: (DIV_BASE << sel) - 1
    for (genvar g = 0; g < N_SEL; g++) begin : g_tab
        assign half_tab[g] = CNT_W'((DIV_BASE << g) - 1);
    end

    assign wrap = (cnt_q == half_tab[sel]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (!run) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (wrap) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign mdc        = phase_q;
    assign rise_pulse = run && wrap && !phase_q;
    assign slot_end   = run && wrap && phase_q;
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               is_wr,
    input  logic [FIELD_W-1:0] phy,
    input  logic [FIELD_W-1:0] regad,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               rise_pulse,
    input  logic               slot_end,
    input  logic               mdio_i,
    output logic               run,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               done,
    output logic [DATA_W-1:0]  rdata,
    output mdio_state_t        state
);
    localparam int HDR_LEN = 4 + 2 * FIELD_W;
    localparam int TA_LEN  = 2;
    localparam int SH_W    = HDR_LEN + TA_LEN + DATA_W;
    localparam int CNT_W   = $clog2(PRE_LEN + SH_W) + 1;

    mdio_state_t       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [SH_W-1:0]   tx_q;
    logic [DATA_W-1:0] rx_q;
    logic              wr_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (slot_end && cnt_q == CNT_W'(PRE_LEN - 1)) state_d = ST_HEADER;
            ST_HEADER:   if (slot_end && cnt_q == CNT_W'(HDR_LEN - 1)) state_d = ST_TURN;
            ST_TURN:     if (slot_end && cnt_q == CNT_W'(TA_LEN - 1))  state_d = ST_DATA;
            ST_DATA:     if (slot_end && cnt_q == CNT_W'(DATA_W - 1))  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register and frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                if (start) begin
                    tx_q  <= {2'b01, (is_wr ? 2'b01 : 2'b10), phy, regad, 2'b10, wdata};
                    wr_q  <= is_wr;
                    cnt_q <= '0;
                end
            end else if (slot_end) begin
                cnt_q <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
                if (state_q != ST_PREAMBLE)
                    tx_q <= {tx_q[SH_W-2:0], 1'b0};
            end
            if (state_q == ST_DATA && !wr_q && rise_pulse)
                rx_q <= {rx_q[DATA_W-2:0], mdio_i};
        end
    end

    // outputs
    always_comb begin
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        unique case (state_q)
            ST_IDLE:     begin mdio_o = 1'b0;          mdio_oe = 1'b0; end
            ST_PREAMBLE: begin mdio_o = 1'b1;          mdio_oe = 1'b1; end
            ST_HEADER:   begin mdio_o = tx_q[SH_W-1];  mdio_oe = 1'b1; end
            ST_TURN:     begin mdio_o = tx_q[SH_W-1];  mdio_oe = wr_q; end
            ST_DATA:     begin mdio_o = tx_q[SH_W-1];  mdio_oe = wr_q; end
            default:     begin mdio_o = 1'b0;          mdio_oe = 1'b0; end
        endcase
    end

    assign run   = (state_q != ST_IDLE);
    assign done  = (state_q == ST_DATA) && (state_d == ST_IDLE);
    assign rdata = rx_q;
    assign state = state_q;
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_BASE = 2,
    parameter int PRE_LEN  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic        host_sel,
    input  logic [31:0] host_wdata,
    output logic [31:0] cmd_rdata,
    output logic [31:0] data_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [HOST_W-1:0] cmd_q;
    logic [HOST_W-1:0] data_q;
    logic              cmd_wr, data_wr, start;
    logic              run, rise_pulse, slot_end, done;
    logic [DATA_W-1:0] rdata;
    mdio_state_t       fsm_state;

    assign cmd_wr  = host_we && !host_sel;
    assign data_wr = host_we && host_sel;
    assign start   = cmd_wr && !cmd_q[BUSY_BIT] && host_wdata[BUSY_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else begin
            if (cmd_wr && !cmd_q[BUSY_BIT])
                cmd_q <= host_wdata;
            else if (done)
                cmd_q[BUSY_BIT] <= 1'b0;

            if (done && !cmd_q[WR_BIT])
                data_q <= HOST_W'(rdata);
            else if (data_wr)
                data_q <= host_wdata;
        end
    end

    mdio_clkgen #(
        .DIV_BASE (DIV_BASE),
        .SEL_W    (SEL_W)
    ) u_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .sel        (cmd_q[SEL_LSB +: SEL_W]),
        .mdc        (mdc),
        .rise_pulse (rise_pulse),
        .slot_end   (slot_end)
    );

    mdio_seq #(
        .PRE_LEN (PRE_LEN)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .is_wr      (host_wdata[WR_BIT]),
        .phy        (host_wdata[PHY_LSB +: FIELD_W]),
        .regad      (host_wdata[REG_LSB +: FIELD_W]),
        .wdata      (data_q[DATA_W-1:0]),
        .rise_pulse (rise_pulse),
        .slot_end   (slot_end),
        .mdio_i     (mdio_i),
        .run        (run),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .done       (done),
        .rdata      (rdata),
        .state      (fsm_state)
    );

    assign cmd_rdata  = cmd_q;
    assign data_rdata = data_q;
endmodule

// File: rtl/mdio_ctrl_chk.sv
module mdio_ctrl_chk
    import mdio_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        host_we,
    input logic        host_sel,
    input logic        go_bit,
    input logic [31:0] cmd_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input mdio_state_t state
);
    // R7: quiet bus whenever not busy
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_rdata[BUSY_BIT] |-> (!mdc && !mdio_oe));

    // R2: accepted command raises busy on the next cycle
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !host_sel && go_bit && !cmd_rdata[BUSY_BIT]) |=> cmd_rdata[BUSY_BIT]);

    // R2: sequencer active only while busy is visible
    p_active_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> cmd_rdata[BUSY_BIT]);

    // R8: command write during busy leaves the fields untouched
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !host_sel && cmd_rdata[BUSY_BIT]) |=> (cmd_rdata[30:0] == $past(cmd_rdata[30:0])));

    // R3: preamble drives ones
    p_preamble_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PREAMBLE) |-> (mdio_oe && mdio_o));

    // R5: read releases the line through turnaround and data
    p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_TURN || state == ST_DATA) && !cmd_rdata[WR_BIT]) |-> !mdio_oe);
endmodule

bind mdio_ctrl mdio_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_we   (host_we),
    .host_sel  (host_sel),
    .go_bit    (host_wdata[31]),
    .cmd_rdata (cmd_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .state     (fsm_state)
);

// File: tb/mdio_ctrl_tb.sv
module mdio_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] cmd_rdata, data_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int total = 0, bad = 0;
    int mon_total = 0, mon_bad = 0;
    bit finished = 0;

    typedef struct {
        logic [63:0] bits;
        logic [63:0] oe;
        int          half;
        bit          is_wr;
    } exp_t;
    exp_t exp_q[$];

    logic [15:0] phy_val = '0;
    int          rise_cnt = 0;

    always #2 clk = ~clk;

    mdio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .cmd_rdata(cmd_rdata), .data_rdata(data_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: presents read data for rising edges 48..63
    assign mdio_i = (rise_cnt >= 48 && rise_cnt < 64) ? phy_val[63 - rise_cnt] : 1'b1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic mchk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        mon_total++;
        if (!ok) begin
            mon_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // monitor / scoreboard
    logic        prev_mdc = 1'b0, prev_busy = 1'b0;
    logic [63:0] rec_bits = '0, rec_oe = '0;
    int          hi_len = 0;
    bit          hi_bad = 0;
    int          bad_len = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_rdata[31] && !prev_busy) begin
                rise_cnt = 0; hi_len = 0; hi_bad = 0; rec_bits = '0; rec_oe = '0;
            end
            if (mdc && !prev_mdc) begin
                rec_bits = {rec_bits[62:0], mdio_o};
                rec_oe   = {rec_oe[62:0], mdio_oe};
                rise_cnt = rise_cnt + 1;
            end
            if (mdc) hi_len = hi_len + 1;
            if (!mdc && prev_mdc) begin
                if (exp_q.size() == 0 || hi_len != exp_q[0].half) begin
                    hi_bad = 1; bad_len = hi_len;
                end
                hi_len = 0;
            end
            if (!cmd_rdata[31] && prev_busy) begin
                if (exp_q.size() == 0) begin
                    mchk(0, "R8 unexpected frame", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    mchk(rise_cnt == 64, "R2 mdc rises per frame", 64'(rise_cnt), 64'd64);
                    mchk(!hi_bad, "R6 mdc high phase length", 64'(bad_len), 64'(e.half));
                    mchk(rec_oe == e.oe, e.is_wr ? "R3 output enable pattern" : "R5 release pattern",
                         rec_oe, e.oe);
                    mchk(rec_bits[63:18] == e.bits[63:18], "R3 preamble and header",
                         64'(rec_bits[63:18]), 64'(e.bits[63:18]));
                    if (e.is_wr)
                        mchk(rec_bits[17:0] == e.bits[17:0], "R4 turnaround and data",
                             64'(rec_bits[17:0]), 64'(e.bits[17:0]));
                end
            end
            prev_mdc  = mdc;
            prev_busy = cmd_rdata[31];
        end
    end

    task automatic host_write(input bit sel, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0; host_sel = 1'b0; host_wdata = '0;
    endtask

    function automatic logic [31:0] cmd_word(input bit go, input bit wr, input logic [2:0] sel,
                                             input logic [4:0] rg, input logic [4:0] phy);
        return {go, wr, 11'b0, sel, 3'b0, rg, 3'b0, phy};
    endfunction

    task automatic start_frame(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                               input logic [2:0] sel, input logic [15:0] wd, input logic [15:0] rv);
        exp_t e;
        e.bits  = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
                   (wr ? 2'b10 : 2'b00), (wr ? wd : 16'h0)};
        e.oe    = wr ? {64{1'b1}} : {{46{1'b1}}, 18'b0};
        e.half  = 2 << sel;
        e.is_wr = wr;
        exp_q.push_back(e);
        phy_val = rv;
        if (wr) host_write(1'b1, {16'h0, wd});
        host_write(1'b0, cmd_word(1'b1, wr, sel, rg, phy));
        chk(cmd_rdata[31] == 1'b1, "R2 busy set after command", 64'(cmd_rdata[31]), 64'd1);
    endtask

    task automatic wait_done();
        int n = 0;
        while (cmd_rdata[31] && n < 40000) begin
            @(negedge clk);
            n++;
        end
        chk(cmd_rdata[31] == 1'b0, "R2 busy self-clears", 64'(cmd_rdata[31]), 64'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] saved;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_rdata == 32'h0, "R1 command reset", 64'(cmd_rdata), 64'd0);
        chk(data_rdata == 32'h0, "R1 data reset", 64'(data_rdata), 64'd0);
        chk(!mdc && !mdio_oe, "R1 bus idle after reset", {62'd0, mdc, mdio_oe}, 64'd0);

        // write frame, fastest divider (R3 R4 R6)
        start_frame(1'b1, 5'h01, 5'h1F, 3'd0, 16'hA5C3, 16'h0);
        wait_done();

        // read frame, sel 1 (R5)
        start_frame(1'b0, 5'h1E, 5'h02, 3'd1, 16'h0, 16'h3C5A);
        wait_done();
        chk(data_rdata == 32'h0000_3C5A, "R5 read data captured", 64'(data_rdata), 64'h3C5A);

        // write frame with mid-frame register writes (R8 R9)
        start_frame(1'b1, 5'h00, 5'h00, 3'd3, 16'hFFFF, 16'h0);
        repeat (100) @(negedge clk);
        saved = cmd_rdata;
        host_write(1'b0, cmd_word(1'b1, 1'b0, 3'd5, 5'h07, 5'h09));
        chk(cmd_rdata == saved, "R8 command write while busy ignored", 64'(cmd_rdata), 64'(saved));
        host_write(1'b1, 32'h0000_1234);
        wait_done();
        chk(data_rdata == 32'h0000_1234, "R9 data write during frame kept", 64'(data_rdata), 64'h1234);
        repeat (300) @(negedge clk);
        chk(exp_q.size() == 0 && !cmd_rdata[31], "R8 no extra frame", 64'(exp_q.size()), 64'd0);

        // read frame, slowest divider (R5 R6)
        start_frame(1'b0, 5'h15, 5'h0A, 3'd7, 16'h0, 16'h8001);
        wait_done();
        chk(data_rdata == 32'h0000_8001, "R5 read at slowest divider", 64'(data_rdata), 64'h8001);

        // command write without go bit (R10 R7)
        host_write(1'b0, cmd_word(1'b0, 1'b1, 3'd2, 5'h04, 5'h03) | 32'h0000_00E0);
        chk(cmd_rdata == (cmd_word(1'b0, 1'b1, 3'd2, 5'h04, 5'h03) | 32'h0000_00E0),
            "R10 command stored without start", 64'(cmd_rdata),
            64'(cmd_word(1'b0, 1'b1, 3'd2, 5'h04, 5'h03) | 32'h0000_00E0));
        begin
            bit quiet = 1;
            for (int i = 0; i < 50; i++) begin
                @(negedge clk);
                if (mdc || mdio_oe || cmd_rdata[31]) quiet = 0;
            end
            chk(quiet, "R7 bus quiet while idle", 64'(!quiet), 64'd0);
            chk(exp_q.size() == 0, "R10 no frame started", 64'(exp_q.size()), 64'd0);
        end

        // read frame overwriting earlier data (R5)
        host_write(1'b1, 32'hDEAD_BEEF);
        start_frame(1'b0, 5'h1F, 5'h1F, 3'd0, 16'h0, 16'hFFFF);
        wait_done();
        chk(data_rdata == 32'h0000_FFFF, "R5 upper bits cleared on read", 64'(data_rdata), 64'hFFFF);

        repeat (20) @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
        $finish;
    end
endmodule